// File: doc/BRIEF.md
# Boot Region Lock Guard with Identification Readback

This block keeps two one-way lock bits. One covers a small boot region at the bottom of the address space and one covers a region of the same size at the top. Each lock is set by a one-cycle request from the command decoder. Once set, a lock stays set until reset, which stands for the load of the stored lock state at power-up. The block watches the target address of each program request. A request into a locked region gives a reject pulse and starts no program cycle. A request anywhere else gives a start pulse. A chip-wide erase is allowed only while both locks are clear.

In identification mode, reads at a few fixed addresses are answered by the block instead of the array. It returns a manufacturer code, a device code and a lock-status byte for each region. Reads at any other address, and all reads outside identification mode, leave the valid flag low so that the array data passes through. All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready pair and no back-pressure.

Top module: `boot_lock_guard`

## Requirements
- R1: After reset both locks are clear, `prog_start` and `prog_reject` are low, and `erase_allow` is high.
- R2: A `lock_lo_set` pulse sets the lower lock from the next cycle on. Later pulses change nothing, and only reset clears the lock.
- R3: A `lock_hi_set` pulse sets the upper lock on its own, with no effect on the lower lock.
- R4: The lower region is every address whose bits above bit BOOT_W-1 are all zero. The upper region is every address whose bits above bit BOOT_W-1 are all one. `prog_allow` is low exactly when `prog_addr` lies in a region whose lock is set.
- R5: One cycle after a `prog_req`, exactly one of `prog_start` or `prog_reject` pulses for one cycle, chosen by `prog_allow` in the cycle of the request. Without a request both stay low.
- R6: `erase_allow` is low whenever either lock is set.
- R7: In identification mode, a read at address 2 gives a valid result of 8'hFF when the lower lock is set and 8'hFE when it is clear.
- R8: In identification mode, a read at the top address minus 13 (3FFF2 hex at the default width) reports the upper lock with the same FF/FE codes.
- R9: In identification mode, a read at address 0 gives the manufacturer code (default 8'h1F) and a read at address 1 gives the device code (default 8'hDA), both valid.
- R10: `id_rd_valid` is low for reads at any other address in identification mode and for every read outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both locks |
| lock_lo_set | input | 1 | Set the lower-region lock |
| lock_hi_set | input | 1 | Set the upper-region lock |
| prog_req | input | 1 | Program/sector-erase request, one cycle |
| prog_addr | input | ADDR_W | Target address of the request |
| prog_allow | output | 1 | Target address is not in a locked region |
| prog_start | output | 1 | Registered pulse: program cycle may start |
| prog_reject | output | 1 | Registered pulse: request refused |
| erase_allow | output | 1 | Chip-wide erase permitted |
| id_mode | input | 1 | Identification mode active |
| rd_addr | input | ADDR_W | Read address |
| id_rd_data | output | 8 | Override read data |
| id_rd_valid | output | 1 | Override data replaces array data |

## Verification
The bench builds the block with ADDR_W=12 and BOOT_W=9. This gives 512-byte regions in a 4 KB space, so a quarter of the random addresses fall into a boot region. Region edges such as the last lower address and the first address past it are reached many times. The upper status address moves to FF2 hex at this width, which checks that it is derived from the parameters and not fixed. Directed steps set the locks in both orders between the random phases and read every identification address in each lock state.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;
  localparam int unsigned NUM_REGIONS = 2;
  localparam int unsigned REG_LO = 0;
  localparam int unsigned REG_HI = 1;
  localparam logic [7:0] STAT_LOCKED = 8'hFF;
  localparam logic [7:0] STAT_OPEN   = 8'hFE;
  typedef logic [NUM_REGIONS-1:0] lock_vec_t;
endpackage

// File: rtl/boot_region_decode.sv
module boot_region_decode
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BOOT_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output lock_vec_t         hit
);
  localparam int unsigned TAG_W = ADDR_W - BOOT_W;
  logic [TAG_W-1:0] tag;
  assign tag = addr[ADDR_W-1:BOOT_W];
  assign hit[REG_LO] = (tag == '0);
  assign hit[REG_HI] = (tag == '1);
endmodule

// File: rtl/boot_lock_regs.sv
module boot_lock_regs
  import boot_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lock_vec_t set,
  output lock_vec_t lock_q
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q[g] <= 1'b0;
      else if (set[g]) lock_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_id_readback.sv
module boot_id_readback
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'hDA
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  lock_vec_t         lock_q,
  output logic [7:0]        data,
  output logic              valid
);
  localparam logic [ADDR_W-1:0] MFR_ADDR   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DEV_ADDR   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LO_STAT    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HI_STAT    = {ADDR_W{1'b1}} - ADDR_W'(13);

  always_comb begin
    data  = 8'h00;
    valid = 1'b0;
    if (id_mode) begin
      valid = 1'b1;
      if (rd_addr == MFR_ADDR)      data = MFR_CODE;
      else if (rd_addr == DEV_ADDR) data = DEV_CODE;
      else if (rd_addr == LO_STAT)  data = lock_q[REG_LO] ? STAT_LOCKED : STAT_OPEN;
      else if (rd_addr == HI_STAT)  data = lock_q[REG_HI] ? STAT_LOCKED : STAT_OPEN;
      else                          valid = 1'b0;
    end
  end
endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BOOT_W = 13,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'hDA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_lo_set,
  input  logic              lock_hi_set,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              prog_allow,
  output logic              prog_start,
  output logic              prog_reject,
  output logic              erase_allow,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_rd_data,
  output logic              id_rd_valid
);
  lock_vec_t lock_q;
  lock_vec_t set_vec;
  lock_vec_t hit;

  assign set_vec[REG_LO] = lock_lo_set;
  assign set_vec[REG_HI] = lock_hi_set;

  boot_lock_regs u_locks (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (set_vec),
    .lock_q (lock_q)
  );

  boot_region_decode #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_dec (
    .addr (prog_addr),
    .hit  (hit)
  );

  boot_id_readback #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode (id_mode),
    .rd_addr (rd_addr),
    .lock_q  (lock_q),
    .data    (id_rd_data),
    .valid   (id_rd_valid)
  );

  assign prog_allow  = ~|(hit & lock_q);
  assign erase_allow = ~|lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start  <= 1'b0;
      prog_reject <= 1'b0;
    end else begin
      prog_start  <= prog_req &  prog_allow;
      prog_reject <= prog_req & ~prog_allow;
    end
  end
endmodule

// File: rtl/boot_lock_guard_chk.sv
module boot_lock_guard_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        lock_q,
  input logic              lock_lo_set,
  input logic              lock_hi_set,
  input logic              prog_req,
  input logic              prog_allow,
  input logic              prog_start,
  input logic              prog_reject,
  input logic              erase_allow,
  input logic              id_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        id_rd_data,
  input logic              id_rd_valid
);
  // R2
  lock_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[0] |=> lock_q[0]);
  // R2
  lock_lo_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lo_set |=> lock_q[0]);
  // R3
  lock_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[1] |=> lock_q[1]);
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && prog_reject));
  // R5
  reject_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !prog_allow) |=> prog_reject);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req |=> !(prog_start || prog_reject));
  // R6
  erase_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lo_set || lock_hi_set) |=> !erase_allow);
  // R7
  lo_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == ADDR_W'(2)) |-> (id_rd_valid && id_rd_data[7:1] == 7'h7F));
  // R10
  no_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> !id_rd_valid);
endmodule

bind boot_lock_guard boot_lock_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_q      (lock_q),
  .lock_lo_set (lock_lo_set),
  .lock_hi_set (lock_hi_set),
  .prog_req    (prog_req),
  .prog_allow  (prog_allow),
  .prog_start  (prog_start),
  .prog_reject (prog_reject),
  .erase_allow (erase_allow),
  .id_mode     (id_mode),
  .rd_addr     (rd_addr),
  .id_rd_data  (id_rd_data),
  .id_rd_valid (id_rd_valid)
);

// File: tb/sim_boot_lock_guard.sv
module sim_boot_lock_guard;
  localparam int unsigned AW = 12;
  localparam int unsigned BW = 9;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [AW-1:0] HI_STAT = {AW{1'b1}} - AW'(13);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_lo_set = 0, lock_hi_set = 0, prog_req = 0, id_mode = 0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic prog_allow, prog_start, prog_reject, erase_allow, id_rd_valid;
  logic [7:0] id_rd_data;

  int checks = 0;
  int errors = 0;
  bit m_lo = 0, m_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_lock_guard #(.ADDR_W(AW), .BOOT_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_lo_set(lock_lo_set), .lock_hi_set(lock_hi_set),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_allow(prog_allow),
    .prog_start(prog_start), .prog_reject(prog_reject), .erase_allow(erase_allow),
    .id_mode(id_mode), .rd_addr(rd_addr), .id_rd_data(id_rd_data), .id_rd_valid(id_rd_valid)
  );

  function automatic bit exp_allow(logic [AW-1:0] a);
    bit lo_hit = (a >> BW) == 0;
    bit hi_hit = (a >> BW) == ((1 << (AW - BW)) - 1);
    return !((lo_hit && m_lo) || (hi_hit && m_hi));
  endfunction

  function automatic logic [8:0] exp_id(logic [AW-1:0] a);
    if (a == 0) return {1'b1, 8'h1F};
    if (a == 1) return {1'b1, 8'hDA};
    if (a == 2) return {1'b1, m_lo ? 8'hFF : 8'hFE};
    if (a == HI_STAT) return {1'b1, m_hi ? 8'hFF : 8'hFE};
    return 9'h000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_prog(logic [AW-1:0] a);
    bit e = exp_allow(a);
    prog_req = 1; prog_addr = a;
    #1 check("R4 prog_allow", {31'd0, prog_allow}, {31'd0, e});
    @(negedge clk);
    prog_req = 0;
    check("R5 start/reject", {30'd0, prog_start, prog_reject}, {30'd0, e, !e});
    @(negedge clk);
    check("R5 pulse ends", {30'd0, prog_start, prog_reject}, 32'd0);
  endtask

  task automatic do_read(logic [AW-1:0] a, bit idm, string req);
    logic [8:0] e = idm ? exp_id(a) : 9'h000;
    id_mode = idm; rd_addr = a;
    #1;
    if (e[8]) check(req, {23'd0, id_rd_valid, id_rd_data}, {23'd0, e});
    else      check(req, {31'd0, id_rd_valid}, 32'd0);
    @(negedge clk);
    id_mode = 0;
  endtask

  task automatic set_lock(bit hi);
    if (hi) lock_hi_set = 1; else lock_lo_set = 1;
    @(negedge clk);
    lock_hi_set = 0; lock_lo_set = 0;
    if (hi) m_hi = 1; else m_lo = 1;
    check("R6 erase_allow", {31'd0, erase_allow}, {31'd0, !(m_lo || m_hi)});
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      if (($urandom % 2) == 0) do_prog(a);
      else do_read(($urandom % 3 == 0) ? AW'($urandom % 4) : a, $urandom % 4 != 0, "R10 random read");
    end
  endtask

  task automatic read_all_id(string tag);
    do_read(AW'(0), 1, {tag, " R9 mfr"});
    do_read(AW'(1), 1, {tag, " R9 dev"});
    do_read(AW'(2), 1, {tag, " R7 lo status"});
    do_read(HI_STAT, 1, {tag, " R8 hi status"});
    do_read(AW'(2), 0, {tag, " R10 no id mode"});
    do_read(AW'(3), 1, {tag, " R10 other addr"});
  endtask

  initial begin
    int unsigned seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", {29'd0, prog_start, prog_reject, erase_allow}, 32'd1);
    read_all_id("open");
    do_prog(AW'(0)); do_prog(AW'(1 << BW) - 1); do_prog({AW{1'b1}});
    rand_phase(200);
    set_lock(0);
    read_all_id("lo");
    do_prog(AW'(1 << BW) - 1);  // R4 last lower address blocked
    do_prog(AW'(1 << BW));      // R4 first address past region open
    do_prog({AW{1'b1}});        // R3 upper still open
    rand_phase(200);
    set_lock(0);                // R2 repeat pulse
    read_all_id("lo again");
    set_lock(1);
    read_all_id("both");
    do_prog({AW{1'b1}} - AW'((1 << BW) - 1));
    do_prog({AW{1'b1}} - AW'(1 << BW));
    rand_phase(200);
    rst_n = 0; m_lo = 0; m_hi = 0;
    @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 locks cleared", {31'd0, erase_allow}, 32'd1);
    set_lock(1);
    read_all_id("hi only");     // R3 lower stays open
    do_prog(AW'(5));
    rand_phase(100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule